// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache that software fills and inspects through a small set of control registers. Each of its entries maps two neighbouring virtual pages, one even and one odd, onto two separate physical frames. Every entry has its own page size, which is set by a mask. An entry either matches only one address-space identifier (ASID) or is global and matches any ASID.

Software places a virtual page pair and an ASID in the high-entry register. It places the two frame descriptors in the low-entry registers and the page size in the mask register. It then issues one of four commands: write at the index register, write at the free-running victim counter, probe for a matching entry, or read an entry back into the registers. A separate combinational lookup port translates a virtual address and ASID. It returns hit, valid, dirty, cache attribute and physical frame number of the selected half.

Top module: `paired_tlb`

## Requirements
- R1: After synchronous reset, all control registers read zero except the victim counter, which reads N-1. No entry matches on any lookup or probe until an entry is written.
- R2: A register write is selected by `reg_sel` (0 index, 1 low-entry even, 2 low-entry odd, 3 mask, 4 wired floor, 5 high-entry). Only these fields are kept. For high-entry: ASID in bits [7:0] and page-pair number in bits [31:13], with bits [12:8] reading zero. For each low-entry word: G in bit 0, V in bit 1, D in bit 2, cache attribute in bits [5:3], PFN in bits [25:6]. For mask: bits [24:13]. For index: the low log2(N) bits, with bit 31 cleared.
- R3: `cmd_op` 0 writes the registers into entry (index mod N). `cmd_op` 1 writes them into the entry named by the victim counter in the command cycle.
- R4: An entry matches when it has been written, when it is global or its ASID equals the requested ASID, and when its page-pair number equals the requested one in every bit position above bit 12 that its mask does not cover.
- R5: An entry is global only when bit 0 of both low-entry words was set at write time.
- R6: A probe (`cmd_op` 2) compares against the high-entry register. It loads the index register with the lowest matching entry number and clears bit 31. When nothing matches, it sets bit 31 and keeps the low bits.
- R7: A read (`cmd_op` 3) of entry (index mod N) reloads high-entry as page-pair number OR ASID. It loads the entry's mask, and rebuilds both low-entry words with the entry's global bit in bit 0 of each.
- R8: The lookup half is selected by the lowest address bit at or above bit 12 that the mask does not cover: 0 gives the even descriptor, 1 the odd one. The lowest matching entry is used. `lk_hit` is low on a miss. `lk_valid` is low when the selected half has V clear, and on a miss all lookup data outputs are zero.
- R9: The victim counter decrements every clock. After it reaches the wired floor it returns to N-1, and a write of the wired floor reloads it to N-1.
- R10: `cmd_done` is high exactly in the cycle after a command. A register write presented in the same cycle as a command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Command: 0 write indexed, 1 write victim, 2 probe, 3 read |
| cmd_done | output | 1 | Command completed in previous cycle |
| index_q | output | 32 | Index register, bit 31 probe miss |
| random_q | output | IDX_W (4) | Victim counter |
| wired_q | output | IDX_W (4) | Wired floor |
| entryhi_q | output | 32 | High-entry register |
| entrylo0_q | output | 32 | Even low-entry register |
| entrylo1_q | output | 32 | Odd low-entry register |
| pagemask_q | output | 32 | Mask register |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup ASID |
| lk_hit | output | 1 | Some entry matches |
| lk_valid | output | 1 | Selected half is valid |
| lk_dirty | output | 1 | Selected half is writable |
| lk_cattr | output | 3 | Selected half cache attribute |
| lk_pfn | output | 20 | Selected half frame number |

## Verification
The directed part places 4 KiB pairs and then 16 KiB pairs. It looks up addresses on either side of the select bit, so a half-select error based on a fixed bit 12 shows up. It uses a foreign ASID against entries whose G bit is set in only one low word and then in both, which separates an OR-formed global bit from the AND rule. Duplicate mappings at two indices, followed by a probe and a miss probe, separate lowest-index priority and bit 31 handling from a last-match scan. The random part draws page numbers from a few bases, with four ASIDs and four mask sizes, so collisions are frequent. It also interleaves victim writes at varying counter values with reads and lookups, all against a reference model in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int ASID_W   = 8;
  localparam int PFN_W    = 20;
  localparam int MASK_W   = 12;
  localparam int PAIR_LSB = 13;
  localparam int VPN2_W   = VA_W - PAIR_LSB;
  localparam int LO_W     = 6 + PFN_W;

  localparam logic [2:0] SEL_INDEX = 3'd0;
  localparam logic [2:0] SEL_LO0   = 3'd1;
  localparam logic [2:0] SEL_LO1   = 3'd2;
  localparam logic [2:0] SEL_MASK  = 3'd3;
  localparam logic [2:0] SEL_WIRED = 3'd4;
  localparam logic [2:0] SEL_HI    = 3'd5;

  localparam logic [1:0] OP_WR_IDX = 2'd0;
  localparam logic [1:0] OP_WR_RND = 2'd1;
  localparam logic [1:0] OP_PROBE  = 2'd2;
  localparam logic [1:0] OP_READ   = 2'd3;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic              live;
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic [MASK_W-1:0] mask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } entry_t;

  // Unpack a low-entry word (bit 0 handled separately by the caller).
  function automatic half_t lo_to_half(input logic [LO_W-1:1] w);
    half_t h;
    h.pfn   = w[LO_W-1:6];
    h.cattr = w[5:3];
    h.dirty = w[2];
    h.valid = w[1];
    return h;
  endfunction

  function automatic logic [LO_W-1:0] half_to_lo(input half_t h, input logic g);
    return {h.pfn, h.cattr, h.dirty, h.valid, g};
  endfunction

  // Picks the address bit just above the masked in-page offset.
  function automatic logic odd_half(input logic [MASK_W-1:0] m,
                                    input logic [MASK_W:0]   bits);
    logic [MASK_W+1:0] span;
    span = {1'b0, m, 1'b1} + 1'b1;
    return |(bits & span[MASK_W+1:1]);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; (
  input  logic              live,
  input  logic [VPN2_W-1:0] ent_vpn2,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [MASK_W-1:0] ent_mask,
  input  logic              ent_glob,
  input  logic [VPN2_W-1:0] req_vpn2,
  input  logic [ASID_W-1:0] req_asid,
  output logic              hit
);
  logic [VPN2_W-1:0] care;
  logic              asid_ok;
  logic              page_ok;

  assign care    = ~{{(VPN2_W-MASK_W){1'b0}}, ent_mask};
  assign asid_ok = ent_glob || (ent_asid == req_asid);
  assign page_ok = ((ent_vpn2 ^ req_vpn2) & care) == '0;
  assign hit     = live && asid_ok && page_ok;
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/tlb_random.sv
module tlb_random #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_wdata,
  output logic [IDX_W-1:0] wired_q,
  output logic [IDX_W-1:0] random_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wired_q  <= '0;
      random_q <= TOP;
    end else if (wired_we) begin
      wired_q  <= wired_wdata;
      random_q <= TOP;
    end else if (random_q <= wired_q) begin
      random_q <= TOP;
    end else begin
      random_q <= random_q - 1'b1;
    end
  end

  p_floor_r9: assert property (@(posedge clk) disable iff (rst)
    random_q >= wired_q);
  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!wired_we && random_q > wired_q) |=> (random_q == $past(random_q) - 1'b1));
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    wired_we |=> (random_q == TOP));
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb import tlb_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              cmd_done,
  output logic [31:0]       index_q,
  output logic [IDX_W-1:0]  random_q,
  output logic [IDX_W-1:0]  wired_q,
  output logic [31:0]       entryhi_q,
  output logic [31:0]       entrylo0_q,
  output logic [31:0]       entrylo1_q,
  output logic [31:0]       pagemask_q,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [2:0]        lk_cattr,
  output logic [PFN_W-1:0]  lk_pfn
);
  localparam int TOP_PAD = 32 - PAIR_LSB - MASK_W;

  // Control registers
  logic [IDX_W-1:0]  idx_r;
  logic              miss_r;
  logic [VPN2_W-1:0] hi_vpn2;
  logic [ASID_W-1:0] hi_asid;
  logic [LO_W-1:0]   lo0_r, lo1_r;
  logic [MASK_W-1:0] mask_r;

  entry_t ents [N_ENTRIES];

  logic                 wired_we;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_idx;
  entry_t               wr_ent;
  logic [N_ENTRIES-1:0] lk_hits, pr_hits;
  logic                 lk_any, pr_any;
  logic [IDX_W-1:0]     lk_idx, pr_idx;
  logic                 lk_odd;
  half_t                lk_half;
  logic                 unused_wdata;
  logic                 unused_va;

  assign unused_wdata = ^{reg_wdata[PAIR_LSB-1:ASID_W], reg_wdata[31:LO_W]};
  assign unused_va    = ^lk_va[PAIR_LSB-2:0];

  assign wired_we = reg_we && !cmd_valid && (reg_sel == SEL_WIRED);

  tlb_random #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_random (
    .clk(clk), .rst(rst), .wired_we(wired_we),
    .wired_wdata(reg_wdata[IDX_W-1:0]),
    .wired_q(wired_q), .random_q(random_q)
  );

  // Entry write path
  assign wr_en  = cmd_valid && (cmd_op == OP_WR_IDX || cmd_op == OP_WR_RND);
  assign wr_idx = (cmd_op == OP_WR_RND) ? random_q : idx_r;

  always_comb begin
    wr_ent.live = 1'b1;
    wr_ent.vpn2 = hi_vpn2;
    wr_ent.asid = hi_asid;
    wr_ent.mask = mask_r;
    wr_ent.glob = lo0_r[0] & lo1_r[0];
    wr_ent.even = lo_to_half(lo0_r[LO_W-1:1]);
    wr_ent.odd  = lo_to_half(lo1_r[LO_W-1:1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) ents[i] <= '0;
    end else if (wr_en) begin
      ents[wr_idx] <= wr_ent;
    end
  end

  // Parallel comparators for the lookup port and for probe
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    tlb_match u_lk (
      .live(ents[g].live), .ent_vpn2(ents[g].vpn2), .ent_asid(ents[g].asid),
      .ent_mask(ents[g].mask), .ent_glob(ents[g].glob),
      .req_vpn2(lk_va[VA_W-1:PAIR_LSB]), .req_asid(lk_asid), .hit(lk_hits[g])
    );
    tlb_match u_pr (
      .live(ents[g].live), .ent_vpn2(ents[g].vpn2), .ent_asid(ents[g].asid),
      .ent_mask(ents[g].mask), .ent_glob(ents[g].glob),
      .req_vpn2(hi_vpn2), .req_asid(hi_asid), .hit(pr_hits[g])
    );
  end

  tlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_lk_first (
    .vec(lk_hits), .any(lk_any), .idx(lk_idx)
  );
  tlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pr_first (
    .vec(pr_hits), .any(pr_any), .idx(pr_idx)
  );

  // Lookup result
  assign lk_odd  = odd_half(ents[lk_idx].mask, lk_va[PAIR_LSB-1 +: MASK_W+1]);
  assign lk_half = lk_odd ? ents[lk_idx].odd : ents[lk_idx].even;

  assign lk_hit   = lk_any;
  assign lk_valid = lk_any && lk_half.valid;
  assign lk_dirty = lk_any && lk_half.dirty;
  assign lk_cattr = lk_any ? lk_half.cattr : '0;
  assign lk_pfn   = lk_any ? lk_half.pfn   : '0;

  // Register file and commands; commands take precedence over writes
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_r    <= '0;
      miss_r   <= 1'b0;
      hi_vpn2  <= '0;
      hi_asid  <= '0;
      lo0_r    <= '0;
      lo1_r    <= '0;
      mask_r   <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= cmd_valid;
      if (cmd_valid) begin
        case (cmd_op)
          OP_PROBE: begin
            if (pr_any) begin
              idx_r  <= pr_idx;
              miss_r <= 1'b0;
            end else begin
              miss_r <= 1'b1;
            end
          end
          OP_READ: begin
            hi_vpn2 <= ents[idx_r].vpn2;
            hi_asid <= ents[idx_r].asid;
            mask_r  <= ents[idx_r].mask;
            lo0_r   <= half_to_lo(ents[idx_r].even, ents[idx_r].glob);
            lo1_r   <= half_to_lo(ents[idx_r].odd,  ents[idx_r].glob);
          end
          default: ;
        endcase
      end else if (reg_we) begin
        case (reg_sel)
          SEL_INDEX: begin
            idx_r  <= reg_wdata[IDX_W-1:0];
            miss_r <= 1'b0;
          end
          SEL_LO0:  lo0_r  <= reg_wdata[LO_W-1:0];
          SEL_LO1:  lo1_r  <= reg_wdata[LO_W-1:0];
          SEL_MASK: mask_r <= reg_wdata[PAIR_LSB +: MASK_W];
          SEL_HI: begin
            hi_vpn2 <= reg_wdata[VA_W-1:PAIR_LSB];
            hi_asid <= reg_wdata[ASID_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign index_q    = {miss_r, {(31-IDX_W){1'b0}}, idx_r};
  assign entryhi_q  = {hi_vpn2, {(PAIR_LSB-ASID_W){1'b0}}, hi_asid};
  assign entrylo0_q = {{(32-LO_W){1'b0}}, lo0_r};
  assign entrylo1_q = {{(32-LO_W){1'b0}}, lo1_r};
  assign pagemask_q = {{TOP_PAD{1'b0}}, mask_r, {PAIR_LSB{1'b0}}};

  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> cmd_done);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !cmd_done);
  p_block_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != OP_READ) |=> $stable(entryhi_q));
  p_probe_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PROBE && !pr_any) |=> index_q[31]);
  p_probe_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PROBE && pr_any) |=> !index_q[31]);
  p_valid_hit_r8: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> lk_hit);
endmodule

// File: tb/paired_tlb_test.sv
`timescale 1ns/1ps
module paired_tlb_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        cmd_done;
  logic [31:0] index_q, entryhi_q, entrylo0_q, entrylo1_q, pagemask_q;
  logic [3:0]  random_q, wired_q;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_valid, lk_dirty;
  logic [2:0]  lk_cattr;
  logic [19:0] lk_pfn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  paired_tlb #(.N_ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_done(cmd_done),
    .index_q(index_q), .random_q(random_q), .wired_q(wired_q),
    .entryhi_q(entryhi_q), .entrylo0_q(entrylo0_q), .entrylo1_q(entrylo1_q),
    .pagemask_q(pagemask_q), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_cattr(lk_cattr), .lk_pfn(lk_pfn)
  );

  // Reference model
  logic [31:0] m_idx, m_ehi, m_lo0r, m_lo1r, m_pmr;
  logic [3:0]  m_rand, m_wired;
  logic        m_live [N];
  logic [18:0] m_vpn2 [N];
  logic [7:0]  m_asid [N];
  logic [11:0] m_mask [N];
  logic        m_g    [N];
  logic [31:0] m_lo0  [N];
  logic [31:0] m_lo1  [N];
  int          m_found;

  function automatic logic f_match(input int i, input logic [18:0] vp, input logic [7:0] as);
    logic [18:0] care;
    care = ~{7'b0, m_mask[i]};
    return m_live[i] && (m_g[i] || m_asid[i] == as) && (((m_vpn2[i] ^ vp) & care) == 19'd0);
  endfunction

  function automatic int f_first(input logic [18:0] vp, input logic [7:0] as);
    for (int i = 0; i < N; i++) if (f_match(i, vp, as)) return i;
    return -1;
  endfunction

  function automatic int f_selbit(input logic [11:0] m);
    int pos;
    pos = 12;
    for (int k = 0; k < 12; k++) begin
      if (m[k] && pos == 12 + k) pos = 13 + k;
    end
    return pos;
  endfunction

  task automatic m_write(input int i);
    m_live[i] = 1'b1;
    m_vpn2[i] = m_ehi[31:13];
    m_asid[i] = m_ehi[7:0];
    m_mask[i] = m_pmr[24:13];
    m_g[i]    = m_lo0r[0] & m_lo1r[0];
    m_lo0[i]  = m_lo0r & ~32'd1;
    m_lo1[i]  = m_lo1r & ~32'd1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_ehi = 0; m_lo0r = 0; m_lo1r = 0; m_pmr = 0;
      m_rand = 4'(N-1); m_wired = 0;
      for (int i = 0; i < N; i++) begin
        m_live[i] = 0; m_vpn2[i] = 0; m_asid[i] = 0; m_mask[i] = 0;
        m_g[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
      end
    end else begin
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: m_write(int'(m_idx[3:0]));
          2'd1: m_write(int'(m_rand));
          2'd2: begin
            m_found = f_first(m_ehi[31:13], m_ehi[7:0]);
            if (m_found >= 0) m_idx = 32'(m_found);
            else m_idx[31] = 1'b1;
          end
          default: begin
            m_found = int'(m_idx[3:0]);
            m_ehi  = {m_vpn2[m_found], 5'b0, m_asid[m_found]};
            m_pmr  = {7'b0, m_mask[m_found], 13'b0};
            m_lo0r = m_lo0[m_found] | 32'(m_g[m_found]);
            m_lo1r = m_lo1[m_found] | 32'(m_g[m_found]);
          end
        endcase
      end else if (reg_we) begin
        case (reg_sel)
          3'd0: m_idx  = reg_wdata & 32'h0000_000F;
          3'd1: m_lo0r = reg_wdata & 32'h03FF_FFFF;
          3'd2: m_lo1r = reg_wdata & 32'h03FF_FFFF;
          3'd3: m_pmr  = reg_wdata & 32'h01FF_E000;
          3'd5: m_ehi  = reg_wdata & 32'hFFFF_E0FF;
          default: ;
        endcase
      end
      if (reg_we && !cmd_valid && reg_sel == 3'd4) begin
        m_rand = 4'(N-1); m_wired = reg_wdata[3:0];
      end else if (m_rand <= m_wired) m_rand = 4'(N-1);
      else m_rand = m_rand - 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_regs(input string tag);
    chk({tag, " index"},    index_q,    m_idx);
    chk({tag, " hi"},       entryhi_q,  m_ehi);
    chk({tag, " lo0"},      entrylo0_q, m_lo0r);
    chk({tag, " lo1"},      entrylo1_q, m_lo1r);
    chk({tag, " mask"},     pagemask_q, m_pmr);
    chk("R9 victim",        32'(random_q), 32'(m_rand));
    chk("R9 wired",         32'(wired_q),  32'(m_wired));
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 done idle", 32'(cmd_done), 32'd0);
    cmp_regs("R2");
  endtask

  task automatic do_cmd(input logic [1:0] op, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 done", 32'(cmd_done), 32'd1);
    cmp_regs(tag);
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] as, input string tag);
    int i;
    logic [31:0] lo;
    lk_va = va; lk_asid = as;
    #1;
    i = f_first(va[31:13], as);
    if (i < 0) lo = 32'd0;
    else lo = va[f_selbit(m_mask[i])] ? m_lo1[i] : m_lo0[i];
    chk({tag, " hit"},   32'(lk_hit),   32'(i >= 0));
    chk({tag, " valid"}, 32'(lk_valid), 32'(lo[1]));
    chk({tag, " dirty"}, 32'(lk_dirty), 32'(lo[2]));
    chk({tag, " cattr"}, 32'(lk_cattr), 32'(lo[5:3]));
    chk({tag, " pfn"},   32'(lk_pfn),   32'(lo[25:6]));
  endtask

  function automatic logic [31:0] rnd_va();
    logic [31:0] bases [4];
    bases[0] = 32'h0040_0000; bases[1] = 32'h0080_0000;
    bases[2] = 32'h0100_0000; bases[3] = 32'h0200_0000;
    return bases[$urandom % 4] | ($urandom & 32'h0001_FFFF);
  endfunction

  function automatic logic [31:0] rnd_mask();
    case ($urandom % 4)
      0: return 32'h0000_0000;
      1: return 32'h0000_2000;
      2: return 32'h0000_6000;
      default: return 32'h0001_E000;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 index", index_q, 32'd0);
    chk("R1 hi", entryhi_q, 32'd0);
    chk("R1 victim", 32'(random_q), 32'(N-1));
    lookup(32'h0000_0000, 8'd0, "R1 empty");
    lookup(32'h0040_0000, 8'd5, "R1 empty");
    do_cmd(2'd2, "R1 probe empty");

    // R2 field masking
    reg_write(3'd5, 32'hFFFF_FFFF);
    reg_write(3'd1, 32'hFFFF_FFFF);
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_write(3'd0, 32'hFFFF_FFFF);

    // R3/R4/R8 4 KiB pair at index 3
    reg_write(3'd5, 32'h0040_0005);
    reg_write(3'd1, (32'h100 << 6) | (3 << 3) | 4 | 2);
    reg_write(3'd2, (32'h101 << 6) | 2);
    reg_write(3'd3, 32'd0);
    reg_write(3'd0, 32'd3);
    do_cmd(2'd0, "R3 write indexed");
    lookup(32'h0040_0123, 8'd5, "R8 even");
    lookup(32'h0040_1ABC, 8'd5, "R8 odd");
    lookup(32'h0040_0123, 8'd6, "R4 asid miss");
    lookup(32'h0040_2000, 8'd5, "R4 page miss");

    // R5 global needs both G bits
    reg_write(3'd5, 32'h0080_0001);
    reg_write(3'd1, (32'h300 << 6) | 3);
    reg_write(3'd2, (32'h301 << 6) | 2);
    reg_write(3'd0, 32'd4);
    do_cmd(2'd0, "R5 one G");
    lookup(32'h0080_0000, 8'h77, "R5 one G");
    reg_write(3'd2, (32'h301 << 6) | 3);
    do_cmd(2'd0, "R5 both G");
    lookup(32'h0080_1000, 8'h77, "R5 both G");

    // R6 probe priority and miss
    reg_write(3'd5, 32'h0040_0005);
    reg_write(3'd0, 32'd9);
    do_cmd(2'd0, "R3 duplicate");
    do_cmd(2'd2, "R6 probe lowest");
    reg_write(3'd5, 32'h1234_5005);
    do_cmd(2'd2, "R6 probe miss");

    // R7 read back
    reg_write(3'd0, 32'd4);
    do_cmd(2'd3, "R7 read global");
    reg_write(3'd0, 32'd3);
    do_cmd(2'd3, "R7 read");

    // R8 16 KiB pages and invalid half
    reg_write(3'd3, 32'h0000_6000);
    reg_write(3'd5, 32'h0100_0009);
    reg_write(3'd1, (32'h200 << 6) | 2);
    reg_write(3'd2, (32'h204 << 6) | 2);
    reg_write(3'd0, 32'd5);
    do_cmd(2'd0, "R3 16k");
    lookup(32'h0100_2000, 8'd9, "R8 16k even");
    lookup(32'h0100_4000, 8'd9, "R8 16k odd");
    lookup(32'h0100_8000, 8'd9, "R4 16k miss");
    reg_write(3'd3, 32'd0);
    reg_write(3'd5, 32'h0200_0001);
    reg_write(3'd1, (32'h400 << 6) | 2);
    reg_write(3'd2, (32'h401 << 6));
    reg_write(3'd0, 32'd6);
    do_cmd(2'd0, "R3 invalid half");
    lookup(32'h0200_1000, 8'd1, "R8 invalid half");

    // R9 victim counter and wired floor
    reg_write(3'd4, 32'd12);
    repeat (6) begin
      @(negedge clk);
      cmp_regs("R9 walk");
    end
    do_cmd(2'd1, "R3 write victim");
    reg_write(3'd4, 32'd0);

    // R10 register write during command is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'hDEAD_B0FF;
    @(negedge clk);
    cmd_valid = 1'b0; reg_we = 1'b0;
    chk("R10 done", 32'(cmd_done), 32'd1);
    cmp_regs("R10 blocked");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int act;
      act = int'($urandom % 10);
      if (act < 5) begin
        int s;
        s = int'($urandom % 6);
        case (s)
          0: reg_write(3'd0, $urandom);
          1: reg_write(3'd1, $urandom);
          2: reg_write(3'd2, $urandom);
          3: reg_write(3'd3, rnd_mask());
          4: reg_write(3'd4, $urandom % 8);
          default: reg_write(3'd5, (rnd_va() & 32'hFFFF_FF00) | ($urandom % 4));
        endcase
      end else if (act < 8) begin
        do_cmd(2'($urandom % 4), "R3 R6 R7 random cmd");
      end else begin
        lookup(rnd_va(), 8'($urandom % 4), "R4 R8 random lookup");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule